// File: doc/BRIEF.md
# Backlight PWM generator

This block produces a single pulse-width-modulated output for driving a display backlight. Software sets a duty value, a power-of-two prescaler and an output polarity in one setup register, and picks the time base with a source-select bit. The time base is either a slow-clock enable pulse from outside or every system clock cycle. One output period always lasts 256 prescaled ticks. The output is in its active phase for the first `duty` ticks of each period, so the duty ranges from 0/256 to 255/256. A duty of 256/256 cannot be produced.

Two write-only command registers start and stop the generator. A status bit reports whether a period is actually being produced. Setup changes written while the generator runs are held back until the current period wraps, so no partial pulse ever appears. A stop request also waits for the end of the current period. While stopped, the output rests at its inactive level.

Top module: `bpwm_top`

## Requirements
- R1: The setup register (address 0) stores the duty value in bits 15:8, the polarity in bit 4 and the prescaler select in bits 2:0. It reads back exactly these fields, and every other bit reads 0.
- R2: Bit 0 of the source register (address 1) selects the time base. 0 counts only cycles where `slow_tick` is high. 1 counts every clock cycle.
- R3: A prescaled tick occurs every 2^N time-base events, where N is the prescaler select. N ranges from 0 to 6. A select of 7 behaves exactly like 6.
- R4: One output period is 256 prescaled ticks. The period counter advances once per tick and wraps from 255 to 0.
- R5: Within a period, the output is active while the period count is below the duty value. A duty of 0 never activates the output. A duty of 255 leaves exactly one inactive tick per period.
- R6: With polarity 1, the active level is high. With polarity 0, the active level is low. While the generator is not running, the output holds the inactive level of the current polarity.
- R7: Writing 1 to bit 0 of the start register (address 2) while idle arms the generator. Status (address 4, bit 0) still reads 0 until the first prescaled tick and reads 1 from the following cycle.
- R8: Writing 1 to bit 0 of the stop register (address 3) while running lets the current period finish. Status falls to 0 in the cycle after the wrap. A start written before that wrap cancels the stop.
- R9: Changes to duty, polarity or prescaler made while running take effect only at the next wrap from count 255 to 0.
- R10: A write with bit 0 = 0 to the start or stop register has no effect, and both addresses always read 0.
- R11: After reset, all register fields are 0, status is 0 and the output is high (the inactive level for polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable pulse marking each slow-clock event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address, for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The bench runs a behavioural model of period count, prescaler phase and pending stop alongside the block and compares the output on every cycle. It also measures active-cycle counts over whole periods.

- A design that applied setup writes immediately would show a distorted period after each mid-run change.
- A design that dropped a stop at once would cut the last pulse short, and status would fall before the wrap.
- A prescaler that treated select 7 as a divide-by-128 would double the active count in the slowest mode.
- A duty comparison using "less than or equal" would produce 256 active ticks at duty 255, and a single tick at duty 0.

The status bit is read back in the cycle right after a start write, to catch a design that reports running before the first tick.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int CMP_W    = 8;
  localparam int PRE_W    = 3;
  localparam int PRE_MAX  = 6;
  // field positions inside the register words
  localparam int CMP_LSB  = 8;
  localparam int POL_BIT  = 4;
  localparam int PRE_LSB  = 0;
  localparam int SRC_BIT  = 0;
  localparam int CMD_BIT  = 0;
  localparam int STAT_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    RA_SETUP  = 3'd0,
    RA_SOURCE = 3'd1,
    RA_START  = 3'd2,
    RA_STOP   = 3'd3,
    RA_STATUS = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_DRAIN
  } run_state_e;
endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
#(
  parameter int CW = CMP_W,
  parameter int PW = PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              run,
  output logic [CW-1:0]     cfg_cmp,
  output logic              cfg_pol,
  output logic [PW-1:0]     cfg_pre,
  output logic              cfg_src,
  output logic              start_cmd,
  output logic              stop_cmd
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(reg_addr);

  logic [CW-1:0] cmp_q, cmp_d;
  logic          pol_q, pol_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          src_q, src_d;

  // next-state for the stored fields
  always_comb begin
    cmp_d = cmp_q;
    pol_d = pol_q;
    pre_d = pre_q;
    src_d = src_q;
    if (reg_we && ra == RA_SETUP) begin
      cmp_d = reg_wdata[CMP_LSB +: CW];
      pol_d = reg_wdata[POL_BIT];
      pre_d = reg_wdata[PRE_LSB +: PW];
    end
    if (reg_we && ra == RA_SOURCE) begin
      src_d = reg_wdata[SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      pol_q <= 1'b0;
      pre_q <= '0;
      src_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pol_q <= pol_d;
      pre_q <= pre_d;
      src_q <= src_d;
    end
  end

  // command strobes: only a written 1 in the command bit counts
  assign start_cmd = reg_we && (ra == RA_START) && reg_wdata[CMD_BIT];
  assign stop_cmd  = reg_we && (ra == RA_STOP)  && reg_wdata[CMD_BIT];

  always_comb begin
    reg_rdata = '0;
    case (ra)
      RA_SETUP: begin
        reg_rdata[CMP_LSB +: CW] = cmp_q;
        reg_rdata[POL_BIT]       = pol_q;
        reg_rdata[PRE_LSB +: PW] = pre_q;
      end
      RA_SOURCE: reg_rdata[SRC_BIT]  = src_q;
      RA_STATUS: reg_rdata[STAT_BIT] = run;
      default:   reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign cfg_cmp = cmp_q;
  assign cfg_pol = pol_q;
  assign cfg_pre = pre_q;
  assign cfg_src = src_q;
endmodule

// File: rtl/bpwm_prescale.sv
module bpwm_prescale #(
  parameter int PW      = 3,
  parameter int PRE_MAX = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          base_tick,
  input  logic [PW-1:0] pre_sel,
  output logic          tick
);
  localparam int DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [PW-1:0]    sel_sat;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] div_q, div_d;

  // out-of-range selects saturate to the largest legal divider
  assign sel_sat = (int'(pre_sel) > PRE_MAX) ? PW'(PRE_MAX) : pre_sel;

  // terminal count 2^N - 1 as a thermometer mask
  generate
    for (genvar i = 0; i < DIV_W; i++) begin : g_lim
      assign lim[i] = (i < int'(sel_sat));
    end
  endgenerate

  assign tick = en && base_tick && (div_q == lim);

  always_comb begin
    div_d = div_q;
    if (!en) begin
      div_d = '0;
    end else if (base_tick) begin
      div_d = tick ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/bpwm_core.sv
module bpwm_core
  import bpwm_pkg::*;
#(
  parameter int CW = CMP_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_cmd,
  input  logic          stop_cmd,
  input  logic          tick,
  input  logic [CW-1:0] cfg_cmp,
  input  logic          cfg_pol,
  input  logic [PW-1:0] cfg_pre,
  output logic          run,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] act_cmp,
  output logic          act_pol,
  output logic [PW-1:0] act_pre,
  output logic          pwm_out
);
  localparam logic [CW-1:0] CNT_LAST = '1;

  run_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic          pol_q, pol_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          wrap;
  logic          load;

  assign wrap = tick && (cnt_q == CNT_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        load  = 1'b1;
        cnt_d = '0;
        if (start_cmd) st_d = ST_ARM;
      end
      ST_ARM: begin
        load = 1'b1;
        if (stop_cmd) begin
          st_d = ST_IDLE;
        end else if (tick) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
      end
      ST_RUN: begin
        if (stop_cmd) st_d = ST_DRAIN;
        if (tick) cnt_d = cnt_q + 1'b1;
        if (wrap) load = 1'b1;
      end
      ST_DRAIN: begin
        if (tick) cnt_d = cnt_q + 1'b1;
        if (wrap) load = 1'b1;
        if (start_cmd) begin
          st_d = ST_RUN;
        end else if (wrap) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // working copy of the setup, refreshed only while stopped or at a wrap
  always_comb begin
    cmp_d = cmp_q;
    pol_d = pol_q;
    pre_d = pre_q;
    if (load) begin
      cmp_d = cfg_cmp;
      pol_d = cfg_pol;
      pre_d = cfg_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cmp_q <= '0;
      pol_q <= 1'b0;
      pre_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      pol_q <= pol_d;
      pre_q <= pre_d;
    end
  end

  assign run     = (st_q == ST_RUN) || (st_q == ST_DRAIN);
  assign busy    = (st_q != ST_IDLE);
  assign cnt     = cnt_q;
  assign act_cmp = cmp_q;
  assign act_pol = pol_q;
  assign act_pre = pre_q;
  assign pwm_out = (run && (cnt_q < cmp_q)) ? pol_q : ~pol_q;
endmodule

// File: rtl/bpwm_top.sv
module bpwm_top
  import bpwm_pkg::*;
#(
  parameter int DUTY_W   = CMP_W,
  parameter int PSEL_W   = PRE_W,
  parameter int PSEL_MAX = PRE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic [DUTY_W-1:0] cfg_cmp;
  logic              cfg_pol;
  logic [PSEL_W-1:0] cfg_pre;
  logic              cfg_src;
  logic              start_cmd;
  logic              stop_cmd;
  logic              run;
  logic              busy;
  logic              base_tick;
  logic              pre_tick;
  logic [DUTY_W-1:0] per_cnt;
  logic [DUTY_W-1:0] act_cmp;
  logic              act_pol;
  logic [PSEL_W-1:0] act_pre;

  bpwm_regs #(.CW(DUTY_W), .PW(PSEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run       (run),
    .cfg_cmp   (cfg_cmp),
    .cfg_pol   (cfg_pol),
    .cfg_pre   (cfg_pre),
    .cfg_src   (cfg_src),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd)
  );

  // source select modelled as a choice of clock enable
  assign base_tick = cfg_src ? 1'b1 : slow_tick;

  bpwm_prescale #(.PW(PSEL_W), .PRE_MAX(PSEL_MAX)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .base_tick (base_tick),
    .pre_sel   (act_pre),
    .tick      (pre_tick)
  );

  bpwm_core #(.CW(DUTY_W), .PW(PSEL_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .tick      (pre_tick),
    .cfg_cmp   (cfg_cmp),
    .cfg_pol   (cfg_pol),
    .cfg_pre   (cfg_pre),
    .run       (run),
    .busy      (busy),
    .cnt       (per_cnt),
    .act_cmp   (act_cmp),
    .act_pol   (act_pol),
    .act_pre   (act_pre),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/bpwm_chk.sv
module bpwm_chk
  import bpwm_pkg::*;
#(
  parameter int CW = CMP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pwm_out,
  input logic              run,
  input logic              tick,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     act_cmp,
  input logic              act_pol,
  input logic              cfg_pol
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $stable(cfg_pol)) |-> (pwm_out == !cfg_pol)); // R6

  AST_LAST_TICK_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '1) |-> (pwm_out == !act_pol)); // R5

  AST_RUN_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tick)); // R7

  AST_RUN_FALLS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(tick) && $past(cnt) == '1)); // R8

  AST_DUTY_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !($past(tick) && $past(cnt) == '1)) |-> $stable(act_cmp)); // R9

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_START || reg_addr == RA_STOP) |-> (reg_rdata == '0)); // R10

  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_STATUS) |-> (reg_rdata == DATA_W'(run))); // R7
endmodule

bind bpwm_top bpwm_chk #(.CW(DUTY_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out),
  .run       (run),
  .tick      (pre_tick),
  .cnt       (per_cnt),
  .act_cmp   (act_cmp),
  .act_pol   (act_pol),
  .cfg_pol   (cfg_pol)
);

// File: tb/test_bpwm_top.sv
module test_bpwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int total = 0;
  int bad = 0;
  int ph = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bpwm_top i_bpwm_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slow-clock enable: one pulse every fourth cycle
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    slow_tick = (ph == 0);
  end

  // behavioural reference model
  int m_cmp, m_pol, m_pre, m_src;
  int a_cmp, a_pol, a_pre;
  int m_st, m_cnt, m_div;
  always @(posedge clk) begin
    int base, ps, lim, tk, st_cmd, sp_cmd, o_cmp, o_pol, o_pre, ld;
    if (!rst_n) begin
      m_cmp = 0; m_pol = 0; m_pre = 0; m_src = 0;
      a_cmp = 0; a_pol = 0; a_pre = 0;
      m_st = 0; m_cnt = 0; m_div = 0;
    end else begin
      base = m_src ? 1 : int'(slow_tick);
      ps = (a_pre > 6) ? 6 : a_pre;
      lim = (1 << ps) - 1;
      tk = (m_st != 0 && base == 1 && m_div == lim) ? 1 : 0;
      st_cmd = (reg_we && reg_addr == 3'd2 && reg_wdata[0]) ? 1 : 0;
      sp_cmd = (reg_we && reg_addr == 3'd3 && reg_wdata[0]) ? 1 : 0;
      o_cmp = m_cmp; o_pol = m_pol; o_pre = m_pre;
      if (m_st == 0) m_div = 0;
      else if (base == 1) m_div = tk ? 0 : m_div + 1;
      ld = 0;
      case (m_st)
        0: begin ld = 1; if (st_cmd) m_st = 1; end
        1: begin
          ld = 1;
          if (sp_cmd) m_st = 0;
          else if (tk) begin m_st = 2; m_cnt = 0; end
        end
        2: begin
          if (sp_cmd) m_st = 3;
          if (tk) begin
            if (m_cnt == 255) begin m_cnt = 0; ld = 1; end
            else m_cnt++;
          end
        end
        default: begin
          if (tk) begin
            if (m_cnt == 255) begin m_cnt = 0; ld = 1; if (!st_cmd) m_st = 0; end
            else m_cnt++;
          end
          if (st_cmd) m_st = 2;
        end
      endcase
      if (ld) begin a_cmp = o_cmp; a_pol = o_pol; a_pre = o_pre; end
      if (reg_we && reg_addr == 3'd0) begin
        m_cmp = int'(reg_wdata[15:8]);
        m_pol = int'(reg_wdata[4]);
        m_pre = int'(reg_wdata[2:0]);
      end
      if (reg_we && reg_addr == 3'd1) m_src = int'(reg_wdata[0]);
    end
  end

  // cycle compare of the output against the model
  always @(negedge clk) begin
    int exp;
    if (rst_n && !done) begin
      exp = (m_st >= 2 && m_cnt < a_cmp) ? a_pol : 1 - a_pol;
      check("R4/R5/R6/R9 cycle output", int'(pwm_out), exp);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
  endtask

  task automatic peek(input logic [2:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
    reg_addr = 3'd4;
  endtask

  task automatic measure(input int n, input logic lvl, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out == lvl) c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R4 watchdog actual=150000 expected<150000 cycles");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    int c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    peek(3'd0, d); check("R11 setup after reset", d, 0);
    peek(3'd1, d); check("R11 source after reset", d, 0);
    peek(3'd4, d); check("R11 status after reset", d, 0);
    check("R11 output after reset", int'(pwm_out), 1);

    // R1 field placement, unused bits dropped
    wr(3'd0, 32'hFFFF_40F5);
    peek(3'd0, d); check("R1 setup readback", d, 32'h0000_4015);
    wr(3'd0, 32'h0000_4010);
    wr(3'd1, 32'h0000_0001);
    peek(3'd1, d); check("R2 source readback", d, 1);
    repeat (2) @(negedge clk);
    check("R6 idle level polarity 1", int'(pwm_out), 0);

    // R10 zero command writes do nothing
    wr(3'd2, 32'hFFFF_FFFE);
    repeat (5) @(negedge clk);
    peek(3'd4, d); check("R10 start with bit0=0", d, 0);
    check("R10 output still idle", int'(pwm_out), 0);
    peek(3'd2, d); check("R10 start reads 0", d, 0);
    peek(3'd3, d); check("R10 stop reads 0", d, 0);

    // R7 status timing
    wr(3'd2, 32'h1);
    peek(3'd4, d); check("R7 status before first tick", d, 0);
    @(negedge clk);
    peek(3'd4, d); check("R7 status after first tick", d, 1);

    // R4/R5 duty over one period
    repeat (300) @(negedge clk);
    measure(256, 1'b1, c); check("R5 duty 64 of 256", c, 64);
    wr(3'd0, 32'h0000_FF10);
    repeat (300) @(negedge clk);
    measure(256, 1'b1, c); check("R5 duty 255 cap", c, 255);
    wr(3'd0, 32'h0000_0010);
    repeat (300) @(negedge clk);
    measure(256, 1'b1, c); check("R5 duty 0", c, 0);
    wr(3'd0, 32'h0000_6400);
    repeat (300) @(negedge clk);
    measure(256, 1'b0, c); check("R6 polarity 0 low phase", c, 100);

    // R3 prescaler
    wr(3'd0, 32'h0000_8011);
    repeat (300) @(negedge clk);
    measure(512, 1'b1, c); check("R3 divide by 2", c, 256);
    wr(3'd0, 32'h0000_0A17);
    repeat (600) @(negedge clk);
    measure(16384, 1'b1, c); check("R3 select 7 acts as 6", c, 640);

    // R8 stop waits for wrap
    wr(3'd0, 32'h0000_4010);
    repeat (16500) @(negedge clk);
    wr(3'd3, 32'h1);
    peek(3'd4, d); check("R8 status held after stop", d, 1);
    repeat (300) @(negedge clk);
    peek(3'd4, d); check("R8 status after wrap", d, 0);
    check("R8 idle level after stop", int'(pwm_out), 0);
    wr(3'd2, 32'h1);
    repeat (300) @(negedge clk);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h1);
    repeat (600) @(negedge clk);
    peek(3'd4, d); check("R8 start cancels stop", d, 1);

    // R2 slow time base
    wr(3'd0, 32'h0000_2010);
    wr(3'd1, 32'h0);
    repeat (1100) @(negedge clk);
    measure(1024, 1'b1, c); check("R2 slow base duty", c, 128);
    wr(3'd3, 32'h1);
    repeat (1100) @(negedge clk);
    peek(3'd4, d); check("R2 slow base stop", d, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule